// File: doc/BRIEF.md
# Universal Bidirectional Bus Register

The block sits between two parallel buses, called A and B, and holds one storage path for each direction. The A-to-B path takes its data from the A side and presents it on the B side. The B-to-A path does the reverse. Each path has its own latch enable, path clock and output enable. The latch enable and the clock together put the path into one of three modes: transparent (output follows input), latched (output holds), or clocked (input captured on a falling clock edge).

Each path has a single storage element. While its latch enable is high it acts as an open latch. While the latch enable is low it acts as a flip-flop that triggers on the falling edge of the path clock.

The two output enables have opposite polarity. The A-to-B enable is active-high and the B-to-A enable is active-low. They gate only the drivers, never the storage.

Each bus side is brought out as an input view, an output data view and a drive-enable view. A pad wrapper turns these into a tri-state pin. The data width is a parameter, 18 by default. An asynchronous active-high reset clears both stored values to zero.

Top module: `bidir_bus_reg`

## Requirements
- R1: While a path's latch enable is high, that path's output data equals its input data (A-to-B: `b_o` follows `a_i`; B-to-A: `a_o` follows `b_i`), whatever its clock does.
- R2: While a path's latch enable is low and its clock stays at one level (high or low), the output keeps its last value, and input changes have no effect on it.
- R3: While a path's latch enable is low, a high-to-low transition of that path's clock loads the input present at that edge. The output then shows the loaded value until the next capture or transparent phase.
- R4: A low-to-high transition of a path's clock never changes the value that path holds.
- R5: Suppose the latch enable falls while the path clock is high. The output first holds the value that was in the latch. The next falling clock edge then captures the current input.
- R6: The B-side drive enable `b_oe` equals `oe_ab` (active-high). The A-side drive enable `a_oe` equals the inverse of `oe_ba_n` (active-low). Output data is meaningful only while the matching drive enable is 1.
- R7: Storing, transparency and capture carry on while a path's drive enable is 0. Once the enable returns to 1, the output shows the value stored in the meantime.
- R8: While `rst` is 1, both stored values are cleared to all zeros. After release, with latch enables low, both outputs read zero.
- R9: Activity on one path never changes the value held by the other path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Asynchronous active-high clear of both stored values |
| a_i | input | W | A-side input view (data into the A-to-B path) |
| a_o | output | W | A-side output data from the B-to-A path |
| a_oe | output | 1 | A-side drive enable (1 = drive, 0 = high impedance) |
| b_i | input | W | B-side input view (data into the B-to-A path) |
| b_o | output | W | B-side output data from the A-to-B path |
| b_oe | output | 1 | B-side drive enable (1 = drive, 0 = high impedance) |
| oe_ab | input | 1 | A-to-B output enable, active-high |
| le_ab | input | 1 | A-to-B latch enable (1 = transparent) |
| clk_ab | input | 1 | A-to-B path clock, captures on falling edge |
| oe_ba_n | input | 1 | B-to-A output enable, active-low |
| le_ba | input | 1 | B-to-A latch enable (1 = transparent) |
| clk_ba | input | 1 | B-to-A path clock, captures on falling edge |

## Verification
The hardest case to reach is the ordering in R5: the latch enable drops while the clock is still high, and only afterwards does the clock fall. The same element must then pass from latch behaviour to edge capture without losing either value. The stimulus changes exactly one control line per step, so the enable fall and the clock fall never share a time step. Fresh input data is presented between them, so a held value and a captured value can always be told apart. The same step discipline separates a rising edge (R4) from a falling edge (R3), and each sweep round runs with different data words in both directions.

// File: rtl/ubr_pkg.sv
`timescale 1ns/1ps
package ubr_pkg;

    // Polarity of an output-enable pin
    typedef enum logic {
        OE_HIGH = 1'b0,
        OE_LOW  = 1'b1
    } oe_pol_e;

    // Per-path control bundle
    typedef struct packed {
        logic oe_pin;
        logic le;
        logic clk;
    } path_ctl_t;

    localparam int NUM_PATHS = 2;
    localparam int PATH_AB   = 0;
    localparam int PATH_BA   = 1;

    // Resolve an enable pin into "drive" given its polarity
    function automatic logic oe_active(input logic pin, input oe_pol_e pol);
        return (pol == OE_LOW) ? ~pin : pin;
    endfunction

endpackage

// File: rtl/ubr_store.sv
`timescale 1ns/1ps
// One storage element: open latch while le is high, falling-edge flop while le is low.
module ubr_store #(
    parameter int W = 18
) (
    input  logic         rst,
    input  logic         le,
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] lat_q;
    logic [W-1:0] edge_q;
    logic         edge_newer;

    // Latch half: follows d while le is high, freezes when le drops
    always_latch begin
        if (rst)
            lat_q <= '0;
        else if (le)
            lat_q <= d;
    end

    // Edge half: loads on falling clock while le is low
    always_ff @(negedge clk or posedge rst) begin
        if (rst)
            edge_q <= '0;
        else if (!le)
            edge_q <= d;
    end

    // Tracks whether the edge half holds the more recent value
    always_ff @(negedge clk or posedge rst or posedge le) begin
        if (rst)
            edge_newer <= 1'b0;
        else if (le)
            edge_newer <= 1'b0;
        else
            edge_newer <= 1'b1;
    end

    assign q = edge_newer ? edge_q : lat_q;

endmodule

// File: rtl/ubr_drive.sv
`timescale 1ns/1ps
// Output stage: resolves enable polarity, passes stored data to the pad view.
module ubr_drive
    import ubr_pkg::*;
#(
    parameter int      W   = 18,
    parameter oe_pol_e POL = OE_HIGH
) (
    input  logic         oe_pin,
    input  logic [W-1:0] q,
    output logic [W-1:0] pad_d,
    output logic         pad_en
);
    assign pad_en = oe_active(oe_pin, POL);
    assign pad_d  = q;
endmodule

// File: rtl/bidir_bus_reg.sv
`timescale 1ns/1ps
module bidir_bus_reg
    import ubr_pkg::*;
#(
    parameter int W = 18
) (
    input  logic         rst,
    input  logic [W-1:0] a_i,
    output logic [W-1:0] a_o,
    output logic         a_oe,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] b_o,
    output logic         b_oe,
    input  logic         oe_ab,
    input  logic         le_ab,
    input  logic         clk_ab,
    input  logic         oe_ba_n,
    input  logic         le_ba,
    input  logic         clk_ba
);
    path_ctl_t    ctl    [NUM_PATHS];
    logic [W-1:0] din    [NUM_PATHS];
    logic [W-1:0] qv     [NUM_PATHS];
    logic [W-1:0] drv_d  [NUM_PATHS];
    logic         drv_en [NUM_PATHS];

    assign ctl[PATH_AB] = '{oe_pin: oe_ab,   le: le_ab, clk: clk_ab};
    assign ctl[PATH_BA] = '{oe_pin: oe_ba_n, le: le_ba, clk: clk_ba};
    assign din[PATH_AB] = a_i;
    assign din[PATH_BA] = b_i;

    for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
        localparam oe_pol_e PPOL = (p == PATH_BA) ? OE_LOW : OE_HIGH;

        ubr_store #(.W(W)) u_store (
            .rst (rst),
            .le  (ctl[p].le),
            .clk (ctl[p].clk),
            .d   (din[p]),
            .q   (qv[p])
        );

        ubr_drive #(.W(W), .POL(PPOL)) u_drive (
            .oe_pin (ctl[p].oe_pin),
            .q      (qv[p]),
            .pad_d  (drv_d[p]),
            .pad_en (drv_en[p])
        );
    end

    // A-to-B path drives B side, B-to-A path drives A side
    assign b_o  = drv_d[PATH_AB];
    assign b_oe = drv_en[PATH_AB];
    assign a_o  = drv_d[PATH_BA];
    assign a_oe = drv_en[PATH_BA];

endmodule

// File: rtl/bidir_bus_reg_chk.sv
`timescale 1ns/1ps
module bidir_bus_reg_chk #(
    parameter int W = 18
) (
    input logic         rst,
    input logic [W-1:0] a_i,
    input logic [W-1:0] a_o,
    input logic [W-1:0] b_i,
    input logic [W-1:0] b_o,
    input logic         le_ab,
    input logic         clk_ab,
    input logic         le_ba,
    input logic         clk_ba
);
    logic [W-1:0] seen_ab, seen_ba;
    logic         got_ab, got_ba;

    // Record input at each falling edge taken with latch enable low
    always_ff @(negedge clk_ab or posedge le_ab or posedge rst) begin
        if (rst || le_ab) begin
            got_ab <= 1'b0;
        end else begin
            got_ab  <= 1'b1;
            seen_ab <= a_i;
        end
    end

    always_ff @(negedge clk_ba or posedge le_ba or posedge rst) begin
        if (rst || le_ba) begin
            got_ba <= 1'b0;
        end else begin
            got_ba  <= 1'b1;
            seen_ba <= b_i;
        end
    end

    // R1: transparent path output tracks input
    a_r1_ab_transparent: assert property (@(negedge clk_ab) disable iff (rst)
        le_ab |-> (b_o == a_i));
    a_r1_ba_transparent: assert property (@(negedge clk_ba) disable iff (rst)
        le_ba |-> (a_o == b_i));

    // R3/R4: value captured at falling edge is still shown at the next rising edge
    a_r3_ab_capture: assert property (@(posedge clk_ab) disable iff (rst)
        (got_ab && !le_ab) |-> (b_o == seen_ab));
    a_r3_ba_capture: assert property (@(posedge clk_ba) disable iff (rst)
        (got_ba && !le_ba) |-> (a_o == seen_ba));

endmodule

bind bidir_bus_reg bidir_bus_reg_chk #(.W(W)) u_chk (
    .rst    (rst),
    .a_i    (a_i),
    .a_o    (a_o),
    .b_i    (b_i),
    .b_o    (b_o),
    .le_ab  (le_ab),
    .clk_ab (clk_ab),
    .le_ba  (le_ba),
    .clk_ba (clk_ba)
);

// File: tb/test_bidir_bus_reg.sv
`timescale 1ns/1ps
module test_bidir_bus_reg;
    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] a_i, b_i;
    logic         oe_ab, le_ab, clk_ab, oe_ba_n, le_ba, clk_ba;
    logic [W-1:0] a_o, b_o;
    logic         a_oe, b_oe;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    bidir_bus_reg #(.W(W)) i_bidir_bus_reg (
        .rst(rst), .a_i(a_i), .a_o(a_o), .a_oe(a_oe),
        .b_i(b_i), .b_o(b_o), .b_oe(b_oe),
        .oe_ab(oe_ab), .le_ab(le_ab), .clk_ab(clk_ab),
        .oe_ba_n(oe_ba_n), .le_ba(le_ba), .clk_ba(clk_ba)
    );

    function automatic logic [W-1:0] pat(int k);
        return W'((k * 40503 + 12345) ^ (k << 9));
    endfunction

    function automatic logic [W-1:0] outv(int dir);
        return (dir == 0) ? b_o : a_o;
    endfunction

    task automatic chk(string req, logic [W-1:0] got, logic [W-1:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    // Apply one path's data and controls just after a bench edge, sample at the opposite edge
    task automatic step(int dir, logic [W-1:0] d, logic le, logic ck);
        @(posedge clk); #1;
        if (dir == 0) begin a_i = d; le_ab = le; clk_ab = ck; end
        else          begin b_i = d; le_ba = le; clk_ba = ck; end
        @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [W-1:0] last [2];
        rst = 1'b1; a_i = '0; b_i = '0;
        oe_ab = 1'b1; le_ab = 1'b0; clk_ab = 1'b0;
        oe_ba_n = 1'b0; le_ba = 1'b0; clk_ba = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8 reset b_o", b_o, '0);
        chk("R8 reset a_o", a_o, '0);
        @(posedge clk); #1; rst = 1'b0; @(negedge clk);
        chk("R8 after release b_o", b_o, '0);
        chk("R8 after release a_o", a_o, '0);
        last[0] = '0; last[1] = '0;

        // R6: enable polarity sweep
        for (int e = 0; e < 4; e++) begin
            @(posedge clk); #1; oe_ab = e[0]; oe_ba_n = e[1]; @(negedge clk);
            chk("R6 b_oe", W'(b_oe), W'(e[0]));
            chk("R6 a_oe", W'(a_oe), W'(!e[1]));
        end
        oe_ab = 1'b1; oe_ba_n = 1'b0;

        for (int r = 0; r < 4; r++) begin
            for (int dir = 0; dir < 2; dir++) begin
                int base = r * 16 + dir * 64;
                for (int j = 0; j < 6; j++) begin
                    step(dir, pat(base + j), 1'b1, 1'b0);
                    chk("R1 transparent", outv(dir), pat(base + j));
                end
                step(dir, pat(base + 5), 1'b0, 1'b0);
                chk("R2 le fall clk low", outv(dir), pat(base + 5));
                step(dir, pat(base + 6), 1'b0, 1'b0);
                chk("R2 hold clk low", outv(dir), pat(base + 5));
                step(dir, pat(base + 7), 1'b0, 1'b1);
                chk("R4 rising edge", outv(dir), pat(base + 5));
                step(dir, pat(base + 8), 1'b0, 1'b1);
                chk("R2 hold clk high", outv(dir), pat(base + 5));
                step(dir, pat(base + 9), 1'b0, 1'b0);
                chk("R3 falling capture", outv(dir), pat(base + 9));
                step(dir, pat(base + 10), 1'b0, 1'b0);
                chk("R2 hold after capture", outv(dir), pat(base + 9));
                step(dir, pat(base + 11), 1'b0, 1'b1);
                chk("R4 rising after capture", outv(dir), pat(base + 9));
                // R5: latch enable falls with clock high, then clock falls
                step(dir, pat(base + 12), 1'b1, 1'b1);
                chk("R1 transparent clk high", outv(dir), pat(base + 12));
                step(dir, pat(base + 12), 1'b0, 1'b1);
                chk("R5 le fall clk high", outv(dir), pat(base + 12));
                step(dir, pat(base + 13), 1'b0, 1'b1);
                chk("R5 hold before edge", outv(dir), pat(base + 12));
                step(dir, pat(base + 14), 1'b0, 1'b0);
                chk("R5 edge captures", outv(dir), pat(base + 14));
                last[dir] = pat(base + 14);
                chk("R9 other path untouched", outv(1 - dir), last[1 - dir]);
            end
        end

        // R7: storage continues while drivers are off
        @(posedge clk); #1; oe_ab = 1'b0; oe_ba_n = 1'b1; @(negedge clk);
        chk("R7 b_oe off", W'(b_oe), W'(0));
        chk("R7 a_oe off", W'(a_oe), W'(0));
        for (int dir = 0; dir < 2; dir++) begin
            step(dir, pat(200 + dir), 1'b1, 1'b0);
            step(dir, pat(200 + dir), 1'b0, 1'b0);
            step(dir, pat(210 + dir), 1'b0, 1'b1);
            step(dir, pat(210 + dir), 1'b0, 1'b0);
        end
        @(posedge clk); #1; oe_ab = 1'b1; oe_ba_n = 1'b0; @(negedge clk);
        chk("R7 b_oe on", W'(b_oe), W'(1));
        chk("R7 a_oe on", W'(a_oe), W'(1));
        chk("R7 b_o stored while off", b_o, pat(210));
        chk("R7 a_o stored while off", a_o, pat(211));

        // R8: mid-run reset
        @(posedge clk); #1; rst = 1'b1; @(negedge clk);
        chk("R8 mid reset b_o", b_o, '0);
        chk("R8 mid reset a_o", a_o, '0);
        @(posedge clk); #1; rst = 1'b0; @(negedge clk);
        chk("R8 mid release b_o", b_o, '0);
        chk("R8 mid release a_o", a_o, '0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule